// File: doc/BRIEF.md
# Hybrid-Code Integrator Digital Channel

This block is the digital half of one hybrid-code integrator. An integrator variable is held as a coarse signed count plus an analog remainder. The block keeps two two's-complement registers. The first is a small input counter (5 magnitude bits plus sign). It follows the integrand, one signed unit step at a time, as steps arrive from upstream elements. The second is a wider accumulator (7 magnitude bits plus sign). It holds the digitally exact part of the integral. Both register values are presented as codes for the external DACs, and they stay frozen while the analog channel computes.

A master timer alternates COMPUTE and HOLD periods and signals them on `hold_i`. At the start of each HOLD, a sequencer does the following in order:
1. It latches the two analog-part comparator decisions.
2. It adds the input counter into the accumulator.
3. It applies the carry correction of one unit, in the direction opposite to the carry.
4. It sends a ternary step downstream, as a one-cycle pulse with a polarity level.
5. It commits any upstream step that arrived since the previous HOLD.

The sequencer states are:
- IDLE: COMPUTE; registers frozen.
- LATCH: comparator sampling.
- ADD: accumulate.
- CORR: carry correction.
- EMIT: output step and counter commit.
- DONE: waits for HOLD to end.

The transitions are:
- IDLE→LATCH when `hold_i` is seen high.
- LATCH→ADD→CORR→EMIT→DONE unconditionally, one cycle each.
- DONE→IDLE when `hold_i` is low.

Top module: `hcint_digital`

## Requirements
- R1: While `rst_n` is low, the block does the following on each clock: it loads `init_x_i` into the input counter and `init_r_i` into the accumulator, clears the error and overflow flags, holds `out_pulse_o` and `out_neg_o` low, and returns the sequencer to IDLE.
- R2: While the sequencer is in IDLE with `hold_i` low (COMPUTE), `x_code_o` and `r_code_o` do not change, even when upstream steps arrive.
- R3: A one-cycle pulse on `inc_i` records one upstream step. Its direction is taken from `inc_neg_i`: 0 means +1 and 1 means -1. The step is applied to the input counter in the EMIT cycle of the next HOLD. Only the first step before that commit is kept; further pulses are ignored.
- R4: The input counter saturates at +31 and at -32. A step that would leave this range leaves the counter unchanged and sets `ovf_o`, which stays high until reset.
- R5: In each HOLD, the accumulator adds the sign-extended input counter value that was held during the preceding COMPUTE. The sum wraps modulo 256.
- R6: If `cmp_hi_i` is high and `cmp_lo_i` is low in the first HOLD cycle after IDLE, the accumulator is reduced by 64 (one unit, bit 6). One downstream pulse is then sent with `out_neg_o` low, meaning +1.
- R7: If `cmp_lo_i` is high and `cmp_hi_i` is low in that cycle, the accumulator is increased by 64. One downstream pulse is then sent with `out_neg_o` high, meaning -1.
- R8: If both comparator flags are high in that cycle, no correction is applied and no pulse is sent. `err_o` goes high and stays high until reset.
- R9: The downstream pulse lasts exactly one cycle. It appears on the fifth rising edge that sees `hold_i` high, counting the first such edge. At most one pulse is sent per HOLD, however long `hold_i` stays high. A new sequence needs `hold_i` to go low first.
- R10: `out_neg_o` keeps its value after a pulse, until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads initial values |
| init_x_i | input | 6 | Initial input counter value, two's complement |
| init_r_i | input | 8 | Initial accumulator value, two's complement |
| hold_i | input | 1 | High during HOLD, low during COMPUTE |
| inc_i | input | 1 | Upstream step pulse |
| inc_neg_i | input | 1 | Upstream step polarity, 1 = -1 |
| cmp_hi_i | input | 1 | Analog part above +half unit |
| cmp_lo_i | input | 1 | Analog part below -half unit |
| x_code_o | output | 6 | Input counter value for its DAC |
| r_code_o | output | 8 | Accumulator value for its DAC |
| out_pulse_o | output | 1 | Downstream step pulse |
| out_neg_o | output | 1 | Downstream step polarity, 1 = -1 |
| err_o | output | 1 | Sticky: both comparators asserted |
| ovf_o | output | 1 | Sticky: input counter saturated |

## Verification
The bench runs a table of COMPUTE/HOLD periods against its own model. Each period mixes upstream step directions with comparator outcomes, so every carry direction and the error case occur against changing accumulator contents.

The corner cases it targets are listed below, each with the failure it would expose:
- Counter limits. A counter that wrapped instead of saturating would jump from +31 to -32.
- Two upstream steps in one period. A design that counted both would move the counter by two.
- An accumulator sum past +127. A design that clamped instead of wrapping would show the wrong code.
- A HOLD held high for many cycles. A sequencer that restarted would emit repeated pulses.
- Frozen DAC codes during COMPUTE. A design that committed steps early would let the counter change before HOLD.

// File: rtl/hcint_pkg.sv
package hcint_pkg;

    // HOLD sequencer states, one HOLD sub-step per state
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LATCH = 3'd1,
        ST_ADD   = 3'd2,
        ST_CORR  = 3'd3,
        ST_EMIT  = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

    // Latched comparator verdict
    typedef enum logic [1:0] {
        CY_NONE  = 2'd0,
        CY_RAISE = 2'd1,   // analog part too high: emit +1, take one unit from accumulator
        CY_LOWER = 2'd2,   // analog part too low: emit -1, give one unit to accumulator
        CY_ERROR = 2'd3    // both comparators high
    } carry_e;

    function automatic carry_e decode_cmp(input logic hi, input logic lo);
        unique case ({hi, lo})
            2'b10:   return CY_RAISE;
            2'b01:   return CY_LOWER;
            2'b11:   return CY_ERROR;
            default: return CY_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hcint_seq.sv
module hcint_seq
    import hcint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_i,
    input  logic       cmp_hi_i,
    input  logic       cmp_lo_i,
    output seq_state_e state_o,
    output logic       add_en_o,
    output logic       corr_en_o,
    output carry_e     carry_o,
    output logic       apply_en_o,
    output logic       out_pulse_o,
    output logic       out_neg_o,
    output logic       err_o
);

    seq_state_e state_q, state_d;
    carry_e     cy_q;
    logic       pulse_q, neg_q, err_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hold_i) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_ADD;
            ST_ADD:   state_d = ST_CORR;
            ST_CORR:  state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_DONE;
            ST_DONE:  if (!hold_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and latched verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy_q    <= CY_NONE;
            pulse_q <= 1'b0;
            neg_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (state_q)
                ST_LATCH: begin
                    cy_q <= decode_cmp(cmp_hi_i, cmp_lo_i);
                    if (cmp_hi_i && cmp_lo_i) err_q <= 1'b1;
                end
                ST_EMIT: begin
                    if (cy_q == CY_RAISE || cy_q == CY_LOWER) begin
                        pulse_q <= 1'b1;
                        neg_q   <= (cy_q == CY_LOWER);
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o     = state_q;
    assign add_en_o    = (state_q == ST_ADD);
    assign corr_en_o   = (state_q == ST_CORR);
    assign apply_en_o  = (state_q == ST_EMIT);
    assign carry_o     = cy_q;
    assign out_pulse_o = pulse_q;
    assign out_neg_o   = neg_q;
    assign err_o       = err_q;

    // R9: one-cycle pulse
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R6: high comparator alone gives a +1 pulse four cycles after LATCH
    a_r6_raise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && cmp_hi_i && !cmp_lo_i) |-> ##4 (pulse_q && !neg_q));

    // R7: low comparator alone gives a -1 pulse
    a_r7_lower_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && !cmp_hi_i && cmp_lo_i) |-> ##4 (pulse_q && neg_q));

    // R8: both comparators: no pulse, error raised
    a_r8_both_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && cmp_hi_i && cmp_lo_i) |-> ##4 !pulse_q);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R10: polarity level only moves with a pulse
    a_r10_neg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |=> (pulse_q || $stable(neg_q)));

endmodule

// File: rtl/hcint_xcnt.sv
module hcint_xcnt #(
    parameter int unsigned XMAG = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XMAG:0]   init_i,
    input  logic            inc_i,
    input  logic            inc_neg_i,
    input  logic            apply_i,
    output logic [XMAG:0]   x_o,
    output logic            ovf_o
);

    localparam int unsigned XW = XMAG + 1;
    localparam logic [XW-1:0] XMAX = {1'b0, {XMAG{1'b1}}};
    localparam logic [XW-1:0] XMIN = {1'b1, {XMAG{1'b0}}};

    logic [XW-1:0] x_q;
    logic          pend_q, pend_neg_q, ovf_q;
    logic          step_v, step_neg;

    // effective step at commit: pending one, else one arriving that cycle
    assign step_v   = pend_q | inc_i;
    assign step_neg = pend_q ? pend_neg_q : inc_neg_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q        <= init_i;
            pend_q     <= 1'b0;
            pend_neg_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else if (apply_i) begin
            pend_q <= 1'b0;
            if (step_v) begin
                if (!step_neg) begin
                    if (x_q == XMAX) ovf_q <= 1'b1;
                    else             x_q   <= x_q + 1'b1;
                end else begin
                    if (x_q == XMIN) ovf_q <= 1'b1;
                    else             x_q   <= x_q - 1'b1;
                end
            end
        end else if (inc_i && !pend_q) begin
            pend_q     <= 1'b1;
            pend_neg_q <= inc_neg_i;
        end
    end

    assign x_o   = x_q;
    assign ovf_o = ovf_q;

    // R3: counter moves by at most one unit per cycle
    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (x_q == $past(x_q) || x_q == $past(x_q) + 1'b1 || x_q == $past(x_q) - 1'b1));

    // R4: saturation at both limits
    a_r4_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && step_v && !step_neg && x_q == XMAX) |=> (x_q == XMAX && ovf_q));
    a_r4_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (apply_i && step_v && step_neg && x_q == XMIN) |=> (x_q == XMIN && ovf_q));

endmodule

// File: rtl/hcint_racc.sv
module hcint_racc
    import hcint_pkg::*;
#(
    parameter int unsigned XMAG = 5,
    parameter int unsigned RMAG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RMAG:0]   init_i,
    input  logic [XMAG:0]   x_i,
    input  logic            add_en_i,
    input  logic            corr_en_i,
    input  carry_e          carry_i,
    output logic [RMAG:0]   r_o
);

    localparam int unsigned XW        = XMAG + 1;
    localparam int unsigned RW        = RMAG + 1;
    localparam int unsigned CARRY_POS = XMAG + 1;
    localparam logic [RW-1:0] UNIT =
        {{(RW-CARRY_POS-1){1'b0}}, 1'b1, {CARRY_POS{1'b0}}};

    logic [RW-1:0] r_q;
    logic [RW-1:0] x_ext;

    assign x_ext = {{(RW-XW){x_i[XW-1]}}, x_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= init_i;
        end else if (add_en_i) begin
            r_q <= r_q + x_ext;
        end else if (corr_en_i) begin
            unique case (carry_i)
                CY_RAISE: r_q <= r_q - UNIT;
                CY_LOWER: r_q <= r_q + UNIT;
                default:  ;
            endcase
        end
    end

    assign r_o = r_q;

    // R8: error verdict leaves the accumulator alone in the correction step
    a_r8_no_corr: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en_i && carry_i == CY_ERROR) |=> $stable(r_q));

endmodule

// File: rtl/hcint_digital.sv
module hcint_digital
    import hcint_pkg::*;
#(
    parameter int unsigned XMAG = 5,
    parameter int unsigned RMAG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XMAG:0]   init_x_i,
    input  logic [RMAG:0]   init_r_i,
    input  logic            hold_i,
    input  logic            inc_i,
    input  logic            inc_neg_i,
    input  logic            cmp_hi_i,
    input  logic            cmp_lo_i,
    output logic [XMAG:0]   x_code_o,
    output logic [RMAG:0]   r_code_o,
    output logic            out_pulse_o,
    output logic            out_neg_o,
    output logic            err_o,
    output logic            ovf_o
);

    seq_state_e state;
    carry_e     carry;
    logic       add_en, corr_en, apply_en;

    hcint_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_i),
        .cmp_hi_i    (cmp_hi_i),
        .cmp_lo_i    (cmp_lo_i),
        .state_o     (state),
        .add_en_o    (add_en),
        .corr_en_o   (corr_en),
        .carry_o     (carry),
        .apply_en_o  (apply_en),
        .out_pulse_o (out_pulse_o),
        .out_neg_o   (out_neg_o),
        .err_o       (err_o)
    );

    hcint_xcnt #(.XMAG(XMAG)) u_xcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_x_i),
        .inc_i     (inc_i),
        .inc_neg_i (inc_neg_i),
        .apply_i   (apply_en),
        .x_o       (x_code_o),
        .ovf_o     (ovf_o)
    );

    hcint_racc #(.XMAG(XMAG), .RMAG(RMAG)) u_racc (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_r_i),
        .x_i       (x_code_o),
        .add_en_i  (add_en),
        .corr_en_i (corr_en),
        .carry_i   (carry),
        .r_o       (r_code_o)
    );

    // R2: DAC codes frozen during COMPUTE
    a_r2_compute_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !hold_i) |=> ($stable(x_code_o) && $stable(r_code_o)));

    // R5: the counter is never committed while the accumulator adds it
    a_r5_add_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> $stable(x_code_o));

endmodule

// File: tb/hcint_digital_tb_top.sv
module hcint_digital_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] init_x = '0;
    logic [7:0] init_r = '0;
    logic       hold = 1'b0, inc = 1'b0, inc_neg = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
    logic [5:0] x_code;
    logic [7:0] r_code;
    logic       out_pulse, out_neg, err, ovf;

    always #4 clk = ~clk;   // 125 MHz

    hcint_digital dut_i (
        .clk(clk), .rst_n(rst_n), .init_x_i(init_x), .init_r_i(init_r),
        .hold_i(hold), .inc_i(inc), .inc_neg_i(inc_neg),
        .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
        .x_code_o(x_code), .r_code_o(r_code),
        .out_pulse_o(out_pulse), .out_neg_o(out_neg), .err_o(err), .ovf_o(ovf)
    );

    int total = 0, failed = 0;
    int pulse_cnt = 0;
    int cycles = 0;

    // model state
    int         x_m;
    logic [7:0] r_m;
    logic       err_m, ovf_m, neg_m;

    always @(negedge clk) if (rst_n && out_pulse) pulse_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failed++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int ix, input int ir);
        @(negedge clk);
        rst_n = 1'b0; init_x = 6'(ix); init_r = 8'(ir);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        x_m = ix; r_m = 8'(ir); err_m = 0; ovf_m = 0; neg_m = 0;
    endtask

    // inc_k: 0 none, 1 up, 2 down; n_inc pulses; cmp_k: 0 none, 1 hi, 2 lo, 3 both
    task automatic run_period(input int inc_k, input int n_inc, input int cmp_k);
        int p0;
        int x_before;
        x_before = x_m;
        p0 = pulse_cnt;
        if (inc_k != 0) begin
            for (int i = 0; i < n_inc; i++) begin
                inc = 1'b1; inc_neg = (inc_k == 2);
                @(negedge clk);
                inc = 1'b0;
                @(negedge clk);
            end
            @(negedge clk);
            check("R2 x frozen in compute", $signed(x_code), x_before);
        end
        cmp_hi = (cmp_k == 1 || cmp_k == 3);
        cmp_lo = (cmp_k == 2 || cmp_k == 3);
        hold = 1'b1;
        repeat (10) @(negedge clk);
        hold = 1'b0; cmp_hi = 1'b0; cmp_lo = 1'b0;
        repeat (2) @(negedge clk);
        // model
        r_m = r_m + 8'(x_m);
        if (cmp_k == 1) begin r_m = r_m - 8'd64; neg_m = 0; end
        if (cmp_k == 2) begin r_m = r_m + 8'd64; neg_m = 1; end
        if (cmp_k == 3) err_m = 1;
        if (inc_k == 1) begin if (x_m == 31) ovf_m = 1; else x_m++; end
        if (inc_k == 2) begin if (x_m == -32) ovf_m = 1; else x_m--; end
        check("R3/R4 x after hold", $signed(x_code), x_m);
        check("R5/R6/R7 r after hold", int'(r_code), int'(r_m));
        check("R9 pulses this hold", pulse_cnt - p0, (cmp_k == 1 || cmp_k == 2) ? 1 : 0);
        check("R10 polarity level", int'(out_neg), int'(neg_m));
        check("R8 err flag", int'(err), int'(err_m));
        check("R4 ovf flag", int'(ovf), int'(ovf_m));
    endtask

    // {inc[3:2], cmp[1:0]}
    localparam logic [3:0] VEC [16] = '{
        4'b0000, 4'b0101, 4'b0110, 4'b1001, 4'b0100, 4'b1010, 4'b0001, 4'b0010,
        4'b0101, 4'b0101, 4'b1000, 4'b1001, 4'b0110, 4'b1011, 4'b0001, 4'b0010
    };

    initial begin
        do_reset(5, -10);
        // R1 reset state
        check("R1 x init", $signed(x_code), 5);
        check("R1 r init", int'(r_code), int'(8'hF6));
        check("R1 no pulse", int'(out_pulse), 0);
        check("R1 err clear", int'(err), 0);
        check("R1 ovf clear", int'(ovf), 0);

        foreach (VEC[i]) run_period(int'(VEC[i][3:2]), 1, int'(VEC[i][1:0]));

        // R1: reset clears sticky flags and polarity
        do_reset(30, 0);
        check("R1 err cleared by reset", int'(err), 0);
        check("R1 polarity cleared by reset", int'(out_neg), 0);

        // R4 upper saturation
        run_period(1, 1, 0);
        run_period(1, 1, 0);

        // R4 lower saturation
        do_reset(-31, 0);
        run_period(2, 1, 0);
        run_period(2, 1, 0);

        // R3 two upstream pulses in one period count once
        do_reset(0, 0);
        run_period(1, 2, 0);
        run_period(2, 3, 1);

        // R5 accumulator wraps modulo 256
        do_reset(20, 120);
        run_period(0, 1, 0);
        check("R5 wrap value", int'(r_code), 140);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule